// File: doc/BRIEF.md
# Line-stepped IRQ down-counter

This block is the interrupt timer of a cartridge mapper. The CPU programs a 16-bit count with two byte writes and then arms the timer. Each horizontal sync strobe takes a fixed step of 123 off the count while the timer is armed. When the result is zero or negative, the block raises a level interrupt request, disarms itself and sets the count to 0xFFFF.

The CPU side is a plain write port: address, data and a one-cycle strobe. Four addresses from 0xF000 upward are decoded. Any write to one of them drops a pending interrupt. Writes to any other address are ignored. Bank switching and generation of the sync strobe belong to other blocks.

Top module: `line_irq_timer`

## Requirements
- R1: After reset, irq_o is low, the timer is disarmed and the count is zero. Arming the timer and giving one hsync strobe therefore raises irq_o at once.
- R2: A write to 0xF001 arms the timer. A write to 0xF000 disarms it.
- R3: A write to 0xF002 replaces bits 7:0 of the count. A write to 0xF003 replaces bits 15:8. The other byte keeps its value in both cases.
- R4: A write to any address from 0xF000 to 0xF003 drives irq_o low on the next cycle. A write to any other address changes neither irq_o nor the timer state.
- R5: Each hsync strobe while armed reduces the count by 123. If the result is still positive, irq_o stays low.
- R6: If the reduced count, taken as a 17-bit signed value, is zero or negative, irq_o goes high, the timer disarms and the count becomes 0xFFFF. From 0xFFFF, 533 armed strobes are needed to expire again.
- R7: While the timer is disarmed, hsync strobes leave the count unchanged.
- R8: Once high, irq_o stays high until a decoded write or a reset clears it.
- R9: When a decoded write and an hsync strobe arrive in the same cycle, the write takes effect and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe, one cycle |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| hsync_i | input | 1 | Line strobe, one cycle per line |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench goes after the boundary where the reduced count is exactly zero. A design that tests only for a negative result would need one extra line there. It also checks the reload to 0xFFFF: a wrong reload value or a wrong width changes the number of lines to the next expiry away from 533. Byte loads are checked on top of a nonzero count, where an implementation that clears the other byte expires too early. Writes and hsync strobes are issued in the same cycle, and hsync strobes are given while the timer is disarmed. A design that lets the strobe through in either case ends up with a count that is short by 123, and the following expiry comes one line too early.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_DISARM,
    CMD_ARM,
    CMD_LOAD_LO,
    CMD_LOAD_HI
  } cmd_e;
endpackage

// File: rtl/line_irq_decode.sv
module line_irq_decode
  import line_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF000
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output cmd_e              cmd_o
);
  localparam int NREG = 4;
  cmd_e lut [NREG];
  assign lut[0] = CMD_DISARM;
  assign lut[1] = CMD_ARM;
  assign lut[2] = CMD_LOAD_LO;
  assign lut[3] = CMD_LOAD_HI;

  logic [NREG-1:0] hit;
  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = wr_en_i && (wr_addr_i == BASE_ADDR + ADDR_W'(g));
  end

  always_comb begin
    cmd_o = CMD_NONE;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) cmd_o = lut[i];
    end
  end
endmodule

// File: rtl/line_irq_count.sv
module line_irq_count
  import line_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STEP   = 123
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              hsync_i,
  output logic              expire_o
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [CNT_W:0] STEP_V = (CNT_W+1)'(STEP);

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   diff;
  logic             tick;

  // 17-bit difference: top bit set means the count went below zero
  assign diff     = {1'b0, cnt_q} - STEP_V;
  assign tick     = en_q && hsync_i && (cmd_i == CMD_NONE);
  assign expire_o = tick && (diff[CNT_W] || diff == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      unique case (cmd_i)
        CMD_DISARM:  en_q <= 1'b0;
        CMD_ARM:     en_q <= 1'b1;
        CMD_LOAD_LO: cnt_q[DATA_W-1:0] <= data_i;
        CMD_LOAD_HI: cnt_q[CNT_W-1:DATA_W] <= data_i;
        default: begin
          if (expire_o) begin
            en_q  <= 1'b0;
            cnt_q <= '1;
          end else if (tick) begin
            cnt_q <= diff[CNT_W-1:0];
          end
        end
      endcase
    end
  end

  assert_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_ARM |=> en_q);
  assert_load_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_LOAD_LO |=> cnt_q[CNT_W-1:DATA_W] == $past(cnt_q[CNT_W-1:DATA_W]));
  assert_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !expire_o |=> cnt_q == $past(cnt_q) - CNT_W'(STEP) && en_q);
  assert_expire_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !en_q && cnt_q == '1);
  assert_disarmed_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && cmd_i == CMD_NONE |=> $stable(cnt_q) && !en_q);
  assert_write_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i && (cmd_i == CMD_ARM || cmd_i == CMD_DISARM) |=> $stable(cnt_q));
endmodule

// File: rtl/line_irq_flag.sv
module line_irq_flag
  import line_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic expire_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                irq_q <= 1'b0;
    else if (cmd_i != CMD_NONE) irq_q <= 1'b0;
    else if (expire_i)          irq_q <= 1'b1;
  end

  assign irq_o = irq_q;

  assert_irq_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i != CMD_NONE |=> !irq_o);
  assert_irq_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> irq_o);
  assert_irq_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && cmd_i == CMD_NONE |=> irq_o);
endmodule

// File: rtl/line_irq_timer.sv
module line_irq_timer
  import line_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int STEP   = 123,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              hsync_i,
  output logic              irq_o
);
  cmd_e cmd;
  logic expire;

  line_irq_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .cmd_o     (cmd)
  );

  line_irq_count #(.DATA_W(DATA_W), .STEP(STEP)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .data_i   (wr_data_i),
    .hsync_i  (hsync_i),
    .expire_o (expire)
  );

  line_irq_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .expire_i (expire),
    .irq_o    (irq_o)
  );

  assert_reset_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(hsync_i));
endmodule

// File: tb/line_irq_timer_tb_top.sv
module line_irq_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        hsync = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  // reference model
  bit m_en;
  int m_cnt;
  bit m_irq;

  always #5 clk = ~clk;

  line_irq_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hsync_i(hsync), .irq_o(irq)
  );

  function automatic bit is_reg(input bit we, input logic [15:0] a);
    return we && a >= 16'hF000 && a <= 16'hF003;
  endfunction

  function automatic void model_step(input bit we, input logic [15:0] a,
                                     input logic [7:0] d, input bit hs);
    if (is_reg(we, a)) begin
      case (a)
        16'hF000: m_en = 1'b0;
        16'hF001: m_en = 1'b1;
        16'hF002: m_cnt = (m_cnt & 32'hFF00) | int'(d);
        default:  m_cnt = (m_cnt & 32'h00FF) | (int'(d) << 8);
      endcase
      m_irq = 1'b0;
    end else if (hs && m_en) begin
      m_cnt = m_cnt - 123;
      if (m_cnt <= 0) begin
        m_irq = 1'b1;
        m_en  = 1'b0;
        m_cnt = 32'hFFFF;
      end
    end
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns after the posedge
  task automatic cyc(input bit we, input logic [15:0] a, input logic [7:0] d,
                     input bit hs, input string req);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; hsync = hs;
    @(posedge clk);
    model_step(we, a, d, hs);
    #1;
    check(irq, m_irq, req);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
    cyc(1'b1, a, d, 1'b0, req);
  endtask

  task automatic line(input string req);
    cyc(1'b0, 16'h0000, 8'h00, 1'b1, req);
  endtask

  task automatic idle(input string req);
    cyc(1'b0, 16'h0000, 8'h00, 1'b0, req);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    m_en = 0; m_cnt = 0; m_irq = 0;
    #23;
    check(irq, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    idle("R1");
    check(irq, 1'b0, "R1 after reset");

    // count zero at reset: one line expires
    wr(16'hF001, 8'h00, "R2");
    line("R1");
    check(irq, 1'b1, "R1 zero count expiry");
    repeat (3) idle("R8");
    line("R8");
    check(irq, 1'b1, "R8 level held");

    wr(16'hF000, 8'h00, "R4");
    check(irq, 1'b0, "R4 clear on disarm write");

    // exact zero: 123 - 123
    wr(16'hF002, 8'h7B, "R3");
    wr(16'hF003, 8'h00, "R3");
    wr(16'hF001, 8'h00, "R2");
    line("R6");
    check(irq, 1'b1, "R6 exact zero expiry");

    // count is 0xFFFF now; high byte load keeps low byte -> 0x00FF, 3 lines
    wr(16'hF003, 8'h00, "R3");
    wr(16'hF001, 8'h00, "R2");
    line("R3"); line("R5");
    check(irq, 1'b0, "R5 no expiry while positive");
    line("R3");
    check(irq, 1'b1, "R3 kept low byte 0xFF");

    // unrelated addresses ignored
    wr(16'hF004, 8'h55, "R4");
    wr(16'hE000, 8'h01, "R4");
    check(irq, 1'b1, "R4 unrelated writes ignored");
    wr(16'hF002, 8'hF6, "R4");
    check(irq, 1'b0, "R4 clear on load write");

    // disarmed: 0x00F6=246, lines must not count
    wr(16'hF003, 8'h00, "R3");
    wr(16'hF000, 8'h00, "R2");
    repeat (10) line("R7");
    check(irq, 1'b0, "R7 no expiry while disarmed");
    wr(16'hF001, 8'h00, "R2");
    line("R7");
    check(irq, 1'b0, "R7 count kept after first line");
    line("R7");
    check(irq, 1'b1, "R7 count kept, expiry at second line");

    // write and line in the same cycle
    wr(16'hF002, 8'h7B, "R9");
    wr(16'hF003, 8'h00, "R9");
    wr(16'hF001, 8'h00, "R9");
    cyc(1'b1, 16'hF001, 8'h00, 1'b1, "R9");
    check(irq, 1'b0, "R9 line dropped on write");
    line("R9");
    check(irq, 1'b1, "R9 count untouched by dropped line");

    // reload 0xFFFF: 533 lines
    wr(16'hF001, 8'h00, "R6");
    repeat (532) line("R6");
    check(irq, 1'b0, "R6 before 533rd line");
    line("R6");
    check(irq, 1'b1, "R6 reload 0xFFFF expiry at 533");

    // constrained random against the model
    begin
      int unused;
      unused = $urandom(32'h1F3A);
    end
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit we, hs;
      logic [15:0] a;
      logic [7:0] d;
      r  = int'($urandom_range(0, 99));
      we = (r < 20);
      hs = ($urandom_range(0, 2) == 0);
      a  = ($urandom_range(0, 7) == 0) ? 16'($urandom_range(0, 65535))
                                       : 16'hF000 + 16'($urandom_range(0, 4));
      d  = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(0, 3));
      cyc(we, a, d, hs, "R5 random vs model");
    end

    summary();
  end
endmodule